// File: doc/BRIEF.md
# Branch Target Buffer with Presence-Encoded Taken Prediction

This block caches the destination addresses of taken branches and gives a one-bit direction guess at the same time. No separate counter bits are kept. A branch that owns a valid entry is predicted taken and its stored destination is returned. A branch with no entry is predicted not taken. A branch that resolves taken gets or refreshes an entry, and a branch that resolves not taken loses its entry. The entry's presence is therefore the one-bit history of that static branch.

The storage is set-associative. The set index comes from the program-counter bits just above the ignored alignment bits, and the tag is every bit above the index. `WAYS` sets the number of ways and `SETS` sets the number of sets, so the capacity can be raised to 2048 branches or more. On an install, an empty way of the set is used first. If the set is full, the way with the oldest install or refresh is replaced. Lookups do not change the replacement order.

A fetch stage presents a branch address on the lookup port and takes a registered hit, taken and target result one cycle later. The resolve stage reports each executed branch on the update port with its actual direction and computed destination.

Top module: `ibtb_top`

## Requirements
- R1: After reset no entry is valid: every lookup misses and `lk_done`, `lk_hit`, `lk_taken` and `lk_target` are all zero.
- R2: `lk_done` is high in the cycle after a cycle with `lk_valid` high, and low otherwise.
- R3: A lookup whose address matches a valid entry returns `lk_hit`=1 and `lk_taken`=1 with the stored target.
- R4: A lookup with no matching entry returns `lk_hit`=0, `lk_taken`=0 and `lk_target`=0.
- R5: An update with `up_taken`=1 for an absent branch installs it, so a later lookup hits with `up_target`.
- R6: An update with `up_taken`=1 for a present branch rewrites its target in the same way. A branch never occupies more than one way of a set.
- R7: An update with `up_taken`=0 for a present branch invalidates it, so later lookups miss.
- R8: An update with `up_taken`=0 for an absent branch changes no entry.
- R9: When a lookup and an update arrive in the same cycle, the lookup result reflects the contents before that update.
- R10: An install uses the lowest-numbered invalid way of its set. If all ways are valid, it replaces the way whose last install or refresh is oldest. Lookups and invalidations do not change that order.
- R11: Address bits [ALIGN_BITS-1:0] are ignored. Bits [ALIGN_BITS+log2(SETS)-1:ALIGN_BITS] select the set and all higher bits form the tag. Addresses that differ only in tag bits are separate entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | PC_W | Branch address to look up |
| up_valid | input | 1 | Resolved branch report this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual direction, 1 = taken |
| up_target | input | PC_W | Computed destination of the branch |
| lk_done | output | 1 | Lookup result valid (one cycle after request) |
| lk_hit | output | 1 | Entry found for the looked-up branch |
| lk_taken | output | 1 | Direction guess, 1 = taken |
| lk_target | output | PC_W | Predicted destination, zero on a miss |

## Verification
A lookup result is due in the cycle after the request. An update changes the arrays at the edge that ends the cycle in which it is presented, so a lookup in the next cycle sees it and a lookup in the same cycle does not. The bench changes inputs on falling edges and holds each request for exactly one rising edge. It reads the registered lookup outputs on the following falling edge, which is the first point at which they carry the answer. The same-cycle cases put the lookup and the update on one falling edge and check both the stale answer and the answer one lookup later.

// File: rtl/ibtb_pkg.sv
package ibtb_pkg;

  typedef enum logic [1:0] {
    ACT_IDLE    = 2'd0,
    ACT_INSTALL = 2'd1,
    ACT_REFRESH = 2'd2,
    ACT_DROP    = 2'd3
  } upd_act_e;

  // Resolve outcome and presence decide what happens to the entry.
  function automatic upd_act_e decide_action(input logic vld, input logic taken,
                                             input logic present);
    if (!vld)                 return ACT_IDLE;
    else if (taken && present) return ACT_REFRESH;
    else if (taken)            return ACT_INSTALL;
    else if (present)          return ACT_DROP;
    else                       return ACT_IDLE;
  endfunction

  function automatic logic act_writes(input upd_act_e a);
    return (a == ACT_INSTALL) || (a == ACT_REFRESH);
  endfunction

endpackage

// File: rtl/ibtb_way.sv
module ibtb_way #(
  parameter int SETS  = 64,
  parameter int TAG_W = 24,
  parameter int PC_W  = 32,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] lk_set,
  input  logic [SET_W-1:0] up_set,
  input  logic             wr_en,
  input  logic             clr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_tgt,
  output logic             lk_vld,
  output logic [TAG_W-1:0] lk_tag,
  output logic [PC_W-1:0]  lk_tgt,
  output logic             up_vld,
  output logic [TAG_W-1:0] up_tag
);

  logic [SETS-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q [SETS];
  logic [PC_W-1:0]  tgt_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[up_set] <= 1'b1;
    end else if (clr_en) begin
      vld_q[up_set] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[up_set] <= wr_tag;
      tgt_q[up_set] <= wr_tgt;
    end
  end

  assign lk_vld = vld_q[lk_set];
  assign lk_tag = tag_q[lk_set];
  assign lk_tgt = tgt_q[lk_set];
  assign up_vld = vld_q[up_set];
  assign up_tag = tag_q[up_set];

  // R7: a drop leaves the slot invalid after the edge
  a_r7_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !vld_q[$past(up_set)]);

  // R5: a write leaves a valid slot carrying the written tag
  a_r5_install_visible: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (vld_q[$past(up_set)] && tag_q[$past(up_set)] == $past(wr_tag)));

  // R7: one slot is never written and dropped together
  a_r7_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && clr_en));

endmodule

// File: rtl/ibtb_match.sv
module ibtb_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 24,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [WAYS-1:0]             vld,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags,
  input  logic [TAG_W-1:0]            key,
  output logic [WAYS-1:0]             hit_vec,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way,
  output logic                        free,
  output logic [WAY_W-1:0]            free_way
);

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = vld[w] && (tags[w] == key);
    end
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = hit_way | WAY_W'(w);
    end
  end

  // Lowest-numbered empty way wins.
  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld[w]) free_way = WAY_W'(w);
    end
  end

  assign hit  = |hit_vec;
  assign free = ~&vld;

  // R6: a branch lives in at most one way
  a_r6_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

endmodule

// File: rtl/ibtb_lru.sv
module ibtb_lru #(
  parameter int SETS = 64,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int AGE_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [SET_W-1:0] q_set,
  output logic [WAY_W-1:0] victim
);

  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WAYS - 1);

  logic [AGE_W-1:0] age_q [SETS][WAYS];
  logic [WAYS-1:0]  oldest_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          age_q[s][w] <= AGE_W'(w);
        end
      end
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way) begin
          age_q[touch_set][w] <= '0;
        end else if (age_q[touch_set][w] < age_q[touch_set][touch_way]) begin
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int w = 0; w < WAYS; w++) begin
      oldest_vec[w] = (age_q[q_set][w] == AGE_MAX);
      if (oldest_vec[w]) victim = WAY_W'(w);
    end
  end

  // R10: ages stay a permutation, so exactly one way is oldest
  a_r10_one_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(oldest_vec));

  // R10: the touched way becomes the youngest
  a_r10_touch_youngest: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (age_q[$past(touch_set)][$past(touch_way)] == '0));

endmodule

// File: rtl/ibtb_top.sv
module ibtb_top
  import ibtb_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int SETS       = 64,
  parameter int WAYS       = 4,
  parameter int ALIGN_BITS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic [PC_W-1:0] up_target,
  output logic            lk_done,
  output logic            lk_hit,
  output logic            lk_taken,
  output logic [PC_W-1:0] lk_target
);

  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = PC_W - SET_W - ALIGN_BITS;

  function automatic logic [SET_W-1:0] set_of(input logic [PC_W-1:0] pc);
    return pc[ALIGN_BITS +: SET_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [PC_W-1:0] pc);
    return pc[PC_W-1 -: TAG_W];
  endfunction

  logic [SET_W-1:0] lk_set, up_set;
  logic [TAG_W-1:0] lk_key, up_key;

  assign lk_set = set_of(lk_pc);
  assign up_set = set_of(up_pc);
  assign lk_key = tag_of(lk_pc);
  assign up_key = tag_of(up_pc);

  logic [WAYS-1:0]            lk_vld_w, up_vld_w;
  logic [WAYS-1:0][TAG_W-1:0] lk_tag_w, up_tag_w;
  logic [WAYS-1:0][PC_W-1:0]  lk_tgt_w;
  logic [WAYS-1:0]            wr_en_w, clr_en_w;

  logic [WAYS-1:0]  lk_hit_vec, up_hit_vec;
  logic             lk_match, up_match, up_free;
  logic [WAY_W-1:0] lk_way, up_way, up_free_way, lru_victim, sel_way;
  upd_act_e         act;

  assign act     = decide_action(up_valid, up_taken, up_match);
  assign sel_way = up_match ? up_way : (up_free ? up_free_way : lru_victim);

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    assign wr_en_w[g]  = act_writes(act) && (sel_way == WAY_W'(g));
    assign clr_en_w[g] = (act == ACT_DROP) && (up_way == WAY_W'(g));

    ibtb_way #(.SETS(SETS), .TAG_W(TAG_W), .PC_W(PC_W)) u_way (
      .clk    (clk),
      .rst_n  (rst_n),
      .lk_set (lk_set),
      .up_set (up_set),
      .wr_en  (wr_en_w[g]),
      .clr_en (clr_en_w[g]),
      .wr_tag (up_key),
      .wr_tgt (up_target),
      .lk_vld (lk_vld_w[g]),
      .lk_tag (lk_tag_w[g]),
      .lk_tgt (lk_tgt_w[g]),
      .up_vld (up_vld_w[g]),
      .up_tag (up_tag_w[g])
    );
  end

  ibtb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .clk(clk), .rst_n(rst_n), .vld(lk_vld_w), .tags(lk_tag_w), .key(lk_key),
    .hit_vec(lk_hit_vec), .hit(lk_match), .hit_way(lk_way),
    .free(), .free_way()
  );

  ibtb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_up_match (
    .clk(clk), .rst_n(rst_n), .vld(up_vld_w), .tags(up_tag_w), .key(up_key),
    .hit_vec(up_hit_vec), .hit(up_match), .hit_way(up_way),
    .free(up_free), .free_way(up_free_way)
  );

  ibtb_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (act_writes(act)),
    .touch_set (up_set),
    .touch_way (sel_way),
    .q_set     (up_set),
    .victim    (lru_victim)
  );

  logic [PC_W-1:0] lk_tgt_sel;
  always_comb begin
    lk_tgt_sel = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_hit_vec[w]) lk_tgt_sel = lk_tgt_sel | lk_tgt_w[w];
    end
  end

  // Arrays are read before the update edge, so a same-cycle update is not seen.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_done   <= 1'b0;
      lk_hit    <= 1'b0;
      lk_taken  <= 1'b0;
      lk_target <= '0;
    end else begin
      lk_done   <= lk_valid;
      lk_hit    <= lk_valid && lk_match;
      lk_taken  <= lk_valid && lk_match;
      lk_target <= (lk_valid && lk_match) ? lk_tgt_sel : '0;
    end
  end

  // R2: result follows the request by one cycle
  a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> lk_done);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !lk_done);

  // R3: a hit is always a valid, taken result
  a_r3_hit_taken: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_done && lk_taken));

  // R8: an absent not-taken branch leaves every way untouched
  a_r8_absent_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_taken && !up_match) |-> (wr_en_w == '0 && clr_en_w == '0));

  // R10: a full set installs into the oldest way
  a_r10_full_uses_lru: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_INSTALL && !up_free) |-> (sel_way == lru_victim));

endmodule

// File: tb/tb_ibtb_top.sv
module tb_ibtb_top;

  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            lk_valid = 1'b0;
  logic [PC_W-1:0] lk_pc = '0;
  logic            up_valid = 1'b0;
  logic [PC_W-1:0] up_pc = '0;
  logic            up_taken = 1'b0;
  logic [PC_W-1:0] up_target = '0;
  logic            lk_done, lk_hit, lk_taken;
  logic [PC_W-1:0] lk_target;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ibtb_top #(.PC_W(PC_W), .SETS(64), .WAYS(4), .ALIGN_BITS(2)) dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_target(up_target),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_target(lk_target)
  );

  // Address with tag above bit 8 and set index in bits 7:2.
  function automatic logic [PC_W-1:0] mk(input int tag, input int set);
    return (PC_W'(tag) << 8) | (PC_W'(set) << 2);
  endfunction

  task automatic check(input string req, input logic [PC_W+2:0] act_v,
                       input logic [PC_W+2:0] exp_v);
    n_checks++;
    if (act_v !== exp_v) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  // Result vector packs {done, hit, taken, target}.
  task automatic lookup(input string req, input logic [PC_W-1:0] pc,
                        input logic exp_hit, input logic [PC_W-1:0] exp_tgt);
    lk_valid = 1'b1;
    lk_pc    = pc;
    @(negedge clk);
    lk_valid = 1'b0;
    check(req, {lk_done, lk_hit, lk_taken, lk_target},
          {1'b1, exp_hit, exp_hit, exp_hit ? exp_tgt : '0});
  endtask

  task automatic update(input logic [PC_W-1:0] pc, input logic tk,
                        input logic [PC_W-1:0] tgt);
    up_valid  = 1'b1;
    up_pc     = pc;
    up_taken  = tk;
    up_target = tgt;
    @(negedge clk);
    up_valid  = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 outputs after reset", {lk_done, lk_hit, lk_taken, lk_target}, '0);
    lookup("R1 first lookup misses", mk(1, 3), 1'b0, '0);
    lookup("R4 miss gives zero target", mk(77, 40), 1'b0, '0);
    @(negedge clk);
    check("R2 done drops without request", {2'b0, lk_done, lk_hit, lk_target},
          '0);
  endtask

  task automatic t_install_refresh_drop;
    update(mk(1, 3), 1'b1, 32'hA000_0100);
    lookup("R5 installed branch hits", mk(1, 3), 1'b1, 32'hA000_0100);
    lookup("R3 repeat lookup hits", mk(1, 3), 1'b1, 32'hA000_0100);
    update(mk(1, 3), 1'b1, 32'hB000_0200);
    lookup("R6 refreshed target", mk(1, 3), 1'b1, 32'hB000_0200);
    update(mk(1, 3), 1'b0, 32'h0);
    lookup("R7 dropped branch misses", mk(1, 3), 1'b0, '0);
  endtask

  task automatic t_absent_not_taken;
    update(mk(2, 5), 1'b1, 32'hC000_0300);
    update(mk(3, 5), 1'b0, 32'hDEAD_0000);
    lookup("R8 neighbour untouched", mk(2, 5), 1'b1, 32'hC000_0300);
    lookup("R8 absent branch still misses", mk(3, 5), 1'b0, '0);
  endtask

  task automatic t_same_cycle;
    lk_valid = 1'b1; lk_pc = mk(4, 7);
    up_valid = 1'b1; up_pc = mk(4, 7); up_taken = 1'b1; up_target = 32'hD000_0400;
    @(negedge clk);
    lk_valid = 1'b0; up_valid = 1'b0;
    check("R9 install not seen same cycle", {lk_done, lk_hit, lk_taken, lk_target},
          {1'b1, 1'b0, 1'b0, 32'h0});
    lookup("R9 install seen next cycle", mk(4, 7), 1'b1, 32'hD000_0400);
    lk_valid = 1'b1; lk_pc = mk(4, 7);
    up_valid = 1'b1; up_pc = mk(4, 7); up_taken = 1'b0; up_target = '0;
    @(negedge clk);
    lk_valid = 1'b0; up_valid = 1'b0;
    check("R9 drop not seen same cycle", {lk_done, lk_hit, lk_taken, lk_target},
          {1'b1, 1'b1, 1'b1, 32'hD000_0400});
    lookup("R9 drop seen next cycle", mk(4, 7), 1'b0, '0);
  endtask

  task automatic t_address_fields;
    lookup("R11 low bits ignored", mk(2, 5) | 32'h3, 1'b1, 32'hC000_0300);
    lookup("R11 other tag same set misses", mk(2 + 64, 5), 1'b0, '0);
    lookup("R11 other set misses", mk(2, 6), 1'b0, '0);
  endtask

  task automatic t_replacement;
    for (int t = 1; t <= 4; t++) update(mk(t, 10), 1'b1, 32'h1000 * t);
    update(mk(1, 10), 1'b1, 32'h1111);          // refresh tag 1
    lookup("R10 tag2 present before fill", mk(2, 10), 1'b1, 32'h2000);
    update(mk(5, 10), 1'b1, 32'h5000);          // full set: oldest is tag 2
    lookup("R10 oldest tag2 evicted", mk(2, 10), 1'b0, '0);
    lookup("R10 refreshed tag1 kept", mk(1, 10), 1'b1, 32'h1111);
    lookup("R10 tag3 kept", mk(3, 10), 1'b1, 32'h3000);
    lookup("R10 tag4 kept", mk(4, 10), 1'b1, 32'h4000);
    lookup("R10 tag5 installed", mk(5, 10), 1'b1, 32'h5000);
    update(mk(3, 10), 1'b0, '0);                 // free a way
    update(mk(6, 10), 1'b1, 32'h6000);          // uses freed way
    lookup("R10 empty way used, tag4 kept", mk(4, 10), 1'b1, 32'h4000);
    lookup("R10 empty way used, tag1 kept", mk(1, 10), 1'b1, 32'h1111);
    lookup("R10 tag6 installed", mk(6, 10), 1'b1, 32'h6000);
    update(mk(7, 10), 1'b1, 32'h7000);          // oldest now tag 4
    lookup("R10 tag4 evicted", mk(4, 10), 1'b0, '0);
    lookup("R10 tag1 survives", mk(1, 10), 1'b1, 32'h1111);
    lookup("R10 tag5 survives", mk(5, 10), 1'b1, 32'h5000);
    lookup("R10 tag6 survives", mk(6, 10), 1'b1, 32'h6000);
    lookup("R10 tag7 installed", mk(7, 10), 1'b1, 32'h7000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_install_refresh_drop();
    t_absent_not_taken();
    t_same_cycle();
    t_address_fields();
    t_replacement();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

endmodule